// File: doc/BRIEF.md
# Privileged special-register access unit

This unit executes the two special-register move operations of a processor pipeline: a read ("move from") and a write ("move to") against a 16-bit special-register address space. Each request carries a direction, an address, write data and two privilege qualifiers from the live status word: the supervisor bit and a bit that grants user code access to special registers. The unit returns read data, a warning flag for any rejected or suspicious access, a one-cycle pulse that tells the core to set the flag-overflow (FO) bit, and a redirect to a new fetch address when software writes the next-PC register.

The unit holds the writable system state itself: floating-point control, exception PC, saved status (exported to the core for exception return), the status word, the two accumulator halves (plain storage only), and a bank of shadow general-purpose registers. Three identity words (version, unit presence, CPU configuration) are read-only constants chosen by parameters. The previous-PC value is supplied by the core and is read-only here.

Requests are single-beat with no back-pressure: the unit accepts one request on every cycle that `req_valid` is high and never stalls. Every result is registered and appears exactly one cycle after the request; the consumer must take it in that cycle.

Top module: `spr_access_unit`

Address map (defaults): version 0x0000, unit presence 0x0001, CPU configuration 0x0002, next-PC 0x0010, status 0x0011, previous-PC 0x0012, FP control 0x0014, exception PC 0x0020, saved status 0x0040, shadow bank 0x0400–0x05FF, accumulator low 0x2801, accumulator high 0x2802, timer mode 0x5000, implemented limit 0x6000.

## Requirements
- R1: All outputs are registered; results of a request sampled at a rising edge appear after that edge and last one cycle. `rsp_valid` is 1 exactly in the cycle after a read request, 0 otherwise; after reset every output is 0.
- R2: When neither `priv_super` nor `priv_user_spr` is 1, a read returns 0, a write changes nothing, and `warn` is raised.
- R3: Any address at or above SPR_LIMIT (default 0x6000) is rejected: reads return 0, writes change nothing, `warn` is raised.
- R4: Reads of version, unit presence, configuration, status, previous-PC, FP control, exception PC, accumulator low and high return their current contents without a warning.
- R5: The three identity words are read-only: a write to them raises `warn` and leaves the read value unchanged.
- R6: Writes to FP control, exception PC, saved status, accumulator low and accumulator high store the data without a warning; saved status is visible on `saved_status`.
- R7: A write to status stores the data with bit 15 (FO) forced to 1 and pulses `fo_set` for one cycle.
- R8: A write to next-PC stores nothing, raises no warning, and pulses `redirect_valid` with `redirect_pc` equal to the written data.
- R9: A write to timer mode stores nothing; it raises `warn` only when the data is nonzero. A read of timer mode is invalid (0 with warning).
- R10: The shadow bank at 0x0400–0x05FF (SHADOW_DEPTH entries) is readable and writable; 0x0600 is outside it and invalid.
- R11: Any other address (including reads of next-PC and saved status) is invalid: reads return 0 with `warn`, writes change nothing with `warn`.
- R12: Cycles without `req_valid` and rejected accesses modify no stored state and raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Special-register address |
| req_wdata | input | 32 | Write data |
| priv_super | input | 1 | Supervisor bit of the live status word |
| priv_user_spr | input | 1 | User access to special registers granted |
| prev_pc | input | 32 | Previous-PC value from the core |
| rsp_valid | output | 1 | Read result present |
| rsp_rdata | output | 32 | Read result (0 for rejected reads) |
| redirect_valid | output | 1 | Fetch redirect pulse |
| redirect_pc | output | 32 | Redirect target |
| fo_set | output | 1 | Pulse: set the FO bit |
| warn | output | 1 | Access rejected or suspicious |
| saved_status | output | 32 | Saved status word |

## Verification
Every output of this unit is due exactly one cycle after the edge that samples its request, and state written at that edge is readable by a request in the very next cycle. The bench drives each request at a falling edge, runs its behavioural model on it at once, and compares all outputs against that expectation at the next falling edge, so every clock is checked and a back-to-back write-then-read sees the new value.

// File: rtl/spr_pkg.sv
package spr_pkg;

  localparam int SPR_AW = 16;

  localparam logic [SPR_AW-1:0] ADDR_VERSION = 16'h0000;
  localparam logic [SPR_AW-1:0] ADDR_UNITS   = 16'h0001;
  localparam logic [SPR_AW-1:0] ADDR_CFG     = 16'h0002;
  localparam logic [SPR_AW-1:0] ADDR_NEXTPC  = 16'h0010;
  localparam logic [SPR_AW-1:0] ADDR_STATUS  = 16'h0011;
  localparam logic [SPR_AW-1:0] ADDR_PREVPC  = 16'h0012;
  localparam logic [SPR_AW-1:0] ADDR_FPCTRL  = 16'h0014;
  localparam logic [SPR_AW-1:0] ADDR_EXCPC   = 16'h0020;
  localparam logic [SPR_AW-1:0] ADDR_EXCSR   = 16'h0040;
  localparam logic [SPR_AW-1:0] ADDR_ACCLO   = 16'h2801;
  localparam logic [SPR_AW-1:0] ADDR_ACCHI   = 16'h2802;
  localparam logic [SPR_AW-1:0] ADDR_TMODE   = 16'h5000;

  typedef enum logic [3:0] {
    TGT_NONE, TGT_VERSION, TGT_UNITS, TGT_CFG, TGT_STATUS, TGT_PREVPC,
    TGT_FPCTRL, TGT_EXCPC, TGT_EXCSR, TGT_ACCLO, TGT_ACCHI,
    TGT_NEXTPC, TGT_TMODE, TGT_SHADOW
  } spr_tgt_e;

  typedef struct packed {
    spr_tgt_e tgt;
    logic     can_read;
    logic     can_store;
  } spr_dec_t;

endpackage

// File: rtl/spr_decode.sv
module spr_decode
  import spr_pkg::*;
#(
  parameter int unsigned SPR_LIMIT    = 32'h6000,
  parameter int unsigned SHADOW_BASE  = 32'h0400,
  parameter int unsigned SHADOW_DEPTH = 512,
  parameter int          IDX_W        = $clog2(SHADOW_DEPTH)
) (
  input  logic [SPR_AW-1:0] addr,
  output spr_dec_t          dec,
  output logic [IDX_W-1:0]  shadow_idx
);

  logic [31:0] addr_ext;
  logic        in_limit;
  logic        in_shadow;
  spr_tgt_e    tgt;

  assign addr_ext   = {16'd0, addr};
  assign in_limit   = addr_ext < SPR_LIMIT;
  assign in_shadow  = (addr_ext >= SHADOW_BASE) && (addr_ext < SHADOW_BASE + SHADOW_DEPTH);
  assign shadow_idx = IDX_W'(addr_ext - SHADOW_BASE);

  always_comb begin
    tgt = TGT_NONE;
    if (in_limit) begin
      unique case (addr)
        ADDR_VERSION: tgt = TGT_VERSION;
        ADDR_UNITS:   tgt = TGT_UNITS;
        ADDR_CFG:     tgt = TGT_CFG;
        ADDR_NEXTPC:  tgt = TGT_NEXTPC;
        ADDR_STATUS:  tgt = TGT_STATUS;
        ADDR_PREVPC:  tgt = TGT_PREVPC;
        ADDR_FPCTRL:  tgt = TGT_FPCTRL;
        ADDR_EXCPC:   tgt = TGT_EXCPC;
        ADDR_EXCSR:   tgt = TGT_EXCSR;
        ADDR_ACCLO:   tgt = TGT_ACCLO;
        ADDR_ACCHI:   tgt = TGT_ACCHI;
        ADDR_TMODE:   tgt = TGT_TMODE;
        default:      tgt = in_shadow ? TGT_SHADOW : TGT_NONE;
      endcase
    end
  end

  always_comb begin
    dec.tgt = tgt;
    unique case (tgt)
      TGT_VERSION, TGT_UNITS, TGT_CFG, TGT_PREVPC: begin
        dec.can_read  = 1'b1;
        dec.can_store = 1'b0;
      end
      TGT_STATUS, TGT_FPCTRL, TGT_EXCPC, TGT_ACCLO, TGT_ACCHI, TGT_SHADOW: begin
        dec.can_read  = 1'b1;
        dec.can_store = 1'b1;
      end
      TGT_EXCSR: begin
        dec.can_read  = 1'b0;
        dec.can_store = 1'b1;
      end
      default: begin
        dec.can_read  = 1'b0;
        dec.can_store = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/spr_sysregs.sv
module spr_sysregs
  import spr_pkg::*;
#(
  parameter int                DATA_W      = 32,
  parameter int                FO_BIT      = 15,
  parameter logic [DATA_W-1:0] VERSION_VAL = '0,
  parameter logic [DATA_W-1:0] UNITS_VAL   = '0,
  parameter logic [DATA_W-1:0] CFG_VAL     = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  spr_tgt_e          wr_tgt,
  input  logic [DATA_W-1:0] wdata,
  input  spr_tgt_e          rd_tgt,
  input  logic [DATA_W-1:0] prev_pc,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] saved_status
);

  localparam logic [DATA_W-1:0] FO_MASK = DATA_W'(1) << FO_BIT;

  logic [DATA_W-1:0] status_q, fpctrl_q, excpc_q, excsr_q, acclo_q, acchi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      fpctrl_q <= '0;
      excpc_q  <= '0;
      excsr_q  <= '0;
      acclo_q  <= '0;
      acchi_q  <= '0;
    end else if (wr_en) begin
      unique case (wr_tgt)
        TGT_STATUS: status_q <= wdata | FO_MASK;
        TGT_FPCTRL: fpctrl_q <= wdata;
        TGT_EXCPC:  excpc_q  <= wdata;
        TGT_EXCSR:  excsr_q  <= wdata;
        TGT_ACCLO:  acclo_q  <= wdata;
        TGT_ACCHI:  acchi_q  <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (rd_tgt)
      TGT_VERSION: rd_data = VERSION_VAL;
      TGT_UNITS:   rd_data = UNITS_VAL;
      TGT_CFG:     rd_data = CFG_VAL;
      TGT_STATUS:  rd_data = status_q;
      TGT_PREVPC:  rd_data = prev_pc;
      TGT_FPCTRL:  rd_data = fpctrl_q;
      TGT_EXCPC:   rd_data = excpc_q;
      TGT_ACCLO:   rd_data = acclo_q;
      TGT_ACCHI:   rd_data = acchi_q;
      default:     rd_data = '0;
    endcase
  end

  assign saved_status = excsr_q;

endmodule

// File: rtl/spr_shadow_bank.sv
module spr_shadow_bank #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 512,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wdata;
  end

  assign rd_data = mem[rd_idx];

endmodule

// File: rtl/spr_access_unit.sv
module spr_access_unit
  import spr_pkg::*;
#(
  parameter int unsigned SPR_LIMIT    = 32'h6000,
  parameter int unsigned SHADOW_BASE  = 32'h0400,
  parameter int unsigned SHADOW_DEPTH = 512,
  parameter int          FO_BIT       = 15,
  parameter logic [31:0] VERSION_VAL  = 32'h1200_0003,
  parameter logic [31:0] UNITS_VAL    = 32'h0000_0601,
  parameter logic [31:0] CFG_VAL      = 32'h0000_0020
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [15:0] req_addr,
  input  logic [31:0] req_wdata,
  input  logic        priv_super,
  input  logic        priv_user_spr,
  input  logic [31:0] prev_pc,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        redirect_valid,
  output logic [31:0] redirect_pc,
  output logic        fo_set,
  output logic        warn,
  output logic [31:0] saved_status
);

  localparam int DATA_W = 32;
  localparam int IDX_W  = $clog2(SHADOW_DEPTH);

  spr_dec_t          dec;
  logic [IDX_W-1:0]  sh_idx;
  logic [DATA_W-1:0] sys_rd, sh_rd, rd_mux;
  logic              granted, rd_ok, st_en, npc_hit, tmode_hit, bad_write, bad;

  spr_decode #(
    .SPR_LIMIT   (SPR_LIMIT),
    .SHADOW_BASE (SHADOW_BASE),
    .SHADOW_DEPTH(SHADOW_DEPTH),
    .IDX_W       (IDX_W)
  ) u_decode (
    .addr      (req_addr),
    .dec       (dec),
    .shadow_idx(sh_idx)
  );

  assign granted   = req_valid && (priv_super || priv_user_spr);
  assign rd_ok     = granted && !req_write && dec.can_read;
  assign st_en     = granted && req_write && dec.can_store;
  assign npc_hit   = granted && req_write && (dec.tgt == TGT_NEXTPC);
  assign tmode_hit = granted && req_write && (dec.tgt == TGT_TMODE);
  assign bad_write = req_write && !dec.can_store &&
                     (dec.tgt != TGT_NEXTPC) && (dec.tgt != TGT_TMODE);
  assign bad       = (req_valid && !granted) ||
                     (granted && !req_write && !dec.can_read) ||
                     (granted && bad_write) ||
                     (tmode_hit && (req_wdata != '0));

  spr_sysregs #(
    .DATA_W     (DATA_W),
    .FO_BIT     (FO_BIT),
    .VERSION_VAL(VERSION_VAL),
    .UNITS_VAL  (UNITS_VAL),
    .CFG_VAL    (CFG_VAL)
  ) u_sysregs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (st_en && (dec.tgt != TGT_SHADOW)),
    .wr_tgt      (dec.tgt),
    .wdata       (req_wdata),
    .rd_tgt      (dec.tgt),
    .prev_pc     (prev_pc),
    .rd_data     (sys_rd),
    .saved_status(saved_status)
  );

  spr_shadow_bank #(
    .DATA_W(DATA_W),
    .DEPTH (SHADOW_DEPTH),
    .IDX_W (IDX_W)
  ) u_shadow (
    .clk    (clk),
    .wr_en  (st_en && (dec.tgt == TGT_SHADOW)),
    .wr_idx (sh_idx),
    .wdata  (req_wdata),
    .rd_idx (sh_idx),
    .rd_data(sh_rd)
  );

  assign rd_mux = (dec.tgt == TGT_SHADOW) ? sh_rd : sys_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_rdata      <= '0;
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
      fo_set         <= 1'b0;
      warn           <= 1'b0;
    end else begin
      rsp_valid      <= req_valid && !req_write;
      rsp_rdata      <= rd_ok ? rd_mux : '0;
      redirect_valid <= npc_hit;
      redirect_pc    <= npc_hit ? req_wdata : '0;
      fo_set         <= st_en && (dec.tgt == TGT_STATUS);
      warn           <= bad;
    end
  end

endmodule

// File: rtl/spr_access_checks.sv
module spr_access_checks
  import spr_pkg::*;
#(
  parameter int unsigned SPR_LIMIT = 32'h6000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [15:0] req_addr,
  input logic [31:0] req_wdata,
  input logic        priv_super,
  input logic        priv_user_spr,
  input logic        rsp_valid,
  input logic [31:0] rsp_rdata,
  input logic        redirect_valid,
  input logic [31:0] redirect_pc,
  input logic        fo_set,
  input logic        warn
);

  logic granted;
  assign granted = priv_super || priv_user_spr;

  assert_rsp_due_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  assert_rsp_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  assert_no_priv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !granted) |=> (warn && rsp_rdata == '0 && !redirect_valid && !fo_set));

  assert_beyond_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ({16'd0, req_addr} >= SPR_LIMIT)) |=> (warn && rsp_rdata == '0 && !fo_set));

  assert_fo_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fo_set |-> $past(req_valid && req_write && granted && req_addr == ADDR_STATUS));

  assert_redirect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && granted && req_addr == ADDR_NEXTPC)
      |=> (redirect_valid && redirect_pc == $past(req_wdata) && !warn));

  assert_tmode_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && granted && req_addr == ADDR_TMODE && req_wdata == '0) |=> !warn);

  assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!warn && !redirect_valid && !fo_set));

endmodule

bind spr_access_unit spr_access_checks #(.SPR_LIMIT(SPR_LIMIT)) u_checks (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_write     (req_write),
  .req_addr      (req_addr),
  .req_wdata     (req_wdata),
  .priv_super    (priv_super),
  .priv_user_spr (priv_user_spr),
  .rsp_valid     (rsp_valid),
  .rsp_rdata     (rsp_rdata),
  .redirect_valid(redirect_valid),
  .redirect_pc   (redirect_pc),
  .fo_set        (fo_set),
  .warn          (warn)
);

// File: tb/spr_access_unit_test.sv
module spr_access_unit_test;

  localparam logic [31:0] T_VER   = 32'hA5C3_0102;
  localparam logic [31:0] T_UNITS = 32'h0000_7F11;
  localparam logic [31:0] T_CFG   = 32'h0000_0C20;
  localparam int          T_LIMIT = 'h6000;
  localparam int          SH_LO   = 'h0400;
  localparam int          SH_HI   = 'h05FF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        priv_super = 1'b0, priv_user_spr = 1'b0;
  logic [31:0] prev_pc = '0;
  logic        rsp_valid, redirect_valid, fo_set, warn;
  logic [31:0] rsp_rdata, redirect_pc, saved_status;

  always #10 clk = ~clk;

  spr_access_unit #(
    .VERSION_VAL(T_VER), .UNITS_VAL(T_UNITS), .CFG_VAL(T_CFG)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .priv_super(priv_super),
    .priv_user_spr(priv_user_spr), .prev_pc(prev_pc), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .fo_set(fo_set), .warn(warn),
    .saved_status(saved_status)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  // reference state
  logic [31:0] m_status = 0, m_fp = 0, m_epc = 0, m_esr = 0, m_lo = 0, m_hi = 0;
  logic [31:0] m_sh [int];
  // expectations for the next comparison
  logic        e_rv = 0, e_redir = 0, e_fo = 0, e_warn = 0;
  logic [31:0] e_rd = 0, e_rpc = 0;
  string       e_tag = "R1";

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  task automatic compare();
    chk(e_tag, "rsp_valid", 32'(rsp_valid), 32'(e_rv));
    chk(e_tag, "rsp_rdata", rsp_rdata, e_rd);
    chk(e_tag, "redirect_valid", 32'(redirect_valid), 32'(e_redir));
    chk(e_tag, "redirect_pc", redirect_pc, e_rpc);
    chk(e_tag, "fo_set", 32'(fo_set), 32'(e_fo));
    chk(e_tag, "warn", 32'(warn), 32'(e_warn));
    chk(e_tag, "saved_status", saved_status, m_esr);
  endtask

  // behavioural model of one request
  task automatic model(input bit v, input bit w, input int a, input logic [31:0] d, input bit ps, input bit pu);
    e_rv = v && !w; e_rd = 0; e_redir = 0; e_rpc = 0; e_fo = 0; e_warn = 0;
    if (!v) return;
    if (!(ps || pu) || a >= T_LIMIT) begin e_warn = 1; return; end
    if (!w) begin
      if (a >= SH_LO && a <= SH_HI) e_rd = m_sh[a];
      else case (a)
        'h0000: e_rd = T_VER;
        'h0001: e_rd = T_UNITS;
        'h0002: e_rd = T_CFG;
        'h0011: e_rd = m_status;
        'h0012: e_rd = prev_pc;
        'h0014: e_rd = m_fp;
        'h0020: e_rd = m_epc;
        'h2801: e_rd = m_lo;
        'h2802: e_rd = m_hi;
        default: e_warn = 1;
      endcase
    end else begin
      if (a >= SH_LO && a <= SH_HI) m_sh[a] = d;
      else case (a)
        'h0010: begin e_redir = 1; e_rpc = d; end
        'h0011: begin m_status = d | 32'h0000_8000; e_fo = 1; end
        'h0014: m_fp = d;
        'h0020: m_epc = d;
        'h0040: m_esr = d;
        'h2801: m_lo = d;
        'h2802: m_hi = d;
        'h5000: e_warn = (d != 0);
        default: e_warn = 1;
      endcase
    end
  endtask

  task automatic step(input string tag, input bit v, input bit w, input int a,
                      input logic [31:0] d, input bit ps, input bit pu);
    @(negedge clk);
    compare();
    req_valid = v; req_write = w; req_addr = a[15:0]; req_wdata = d;
    priv_super = ps; priv_user_spr = pu;
    e_tag = tag;
    model(v, w, a, d, ps, pu);
  endtask

  task automatic rd(input string tag, input int a);
    step(tag, 1, 0, a, 32'h0, 1, 0);
  endtask

  task automatic wr(input string tag, input int a, input logic [31:0] d);
    step(tag, 1, 1, a, d, 1, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state, all outputs low
    compare();
    rst_n = 1'b1;

    // R4: constant and core-supplied reads
    prev_pc = 32'hDEAD_0010;
    rd("R4", 'h0000); rd("R4", 'h0001); rd("R4", 'h0002); rd("R4", 'h0012);
    rd("R4", 'h0011);
    // R6: writable registers then back-to-back readback (R1 latency)
    wr("R6", 'h0014, 32'h0000_001F); rd("R6", 'h0014);
    wr("R6", 'h0020, 32'h0000_0100); rd("R6", 'h0020);
    wr("R6", 'h2801, 32'h1357_9BDF); wr("R6", 'h2802, 32'h2468_ACE0);
    rd("R6", 'h2801); rd("R6", 'h2802);
    wr("R6", 'h0040, 32'h0000_0005);
    step("R6", 0, 0, 0, 0, 0, 0);
    // R11: saved status and next-PC are not readable
    rd("R11", 'h0040); rd("R11", 'h0010);
    rd("R11", 'h0003); wr("R11", 'h0013, 32'h77); rd("R11", 'h0013);
    // R7: status write forces FO
    wr("R7", 'h0011, 32'h0000_0001); rd("R7", 'h0011);
    wr("R7", 'h0011, 32'hFFFF_0000); rd("R7", 'h0011);
    // R8: next-PC redirect
    wr("R8", 'h0010, 32'h0000_2000); wr("R8", 'h0010, 32'hF000_0700);
    step("R8", 0, 0, 0, 0, 0, 0);
    // R9: timer mode
    wr("R9", 'h5000, 32'h0); wr("R9", 'h5000, 32'h4000_0000); rd("R9", 'h5000);
    // R5: identity words read-only
    wr("R5", 'h0000, 32'h0); rd("R5", 'h0000); wr("R5", 'h0002, 32'hFFFF_FFFF); rd("R5", 'h0002);
    // R10: shadow bank ends and just outside
    wr("R10", 'h0400, 32'hCAFE_0000); wr("R10", 'h05FF, 32'hBEEF_05FF);
    rd("R10", 'h0400); rd("R10", 'h05FF);
    wr("R10", 'h0600, 32'h1); rd("R10", 'h0600); rd("R10", 'h03FF);
    for (int i = 0; i < 16; i++) wr("R10", 'h0480 + i, 32'h0101_0101 * i + 32'h55);
    for (int i = 0; i < 16; i++) rd("R10", 'h0480 + i);
    // R2: no privilege, then user grant alone
    step("R2", 1, 1, 'h0014, 32'hFFFF, 0, 0);
    step("R2", 1, 0, 'h0014, 0, 0, 0);
    rd("R2", 'h0014);
    step("R2", 1, 1, 'h0014, 32'h0000_0AAA, 0, 1);
    step("R2", 1, 0, 'h0014, 0, 0, 1);
    // R3: beyond the limit
    rd("R3", 'h6000); rd("R3", 'hFFFF); wr("R3", 'h6000, 32'h9); wr("R3", 'h8400, 32'h9);
    rd("R3", 'h5FFF);
    // R12: idle cycles with write-looking inputs have no effect
    step("R12", 0, 1, 'h0014, 32'h1234_5678, 1, 1);
    step("R12", 0, 1, 'h0040, 32'h1234_5678, 1, 1);
    step("R12", 0, 1, 'h0010, 32'h1234_5678, 1, 1);
    rd("R12", 'h0014);
    step("R12", 1, 1, 'h0400, 32'hDEAD_DEAD, 0, 0);
    rd("R12", 'h0400);
    step("R1", 0, 0, 0, 0, 0, 0);
    step("R1", 0, 0, 0, 0, 0, 0);
    finish_run();
  end

endmodule